// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

This block is a bank of general-purpose pins behind a small 32-bit register bus. Each pin has an output-enable bit, an output latch and an input path. On the input path, the pin first passes through a two-flop synchroniser and then through a per-pin polarity inverter. Edge detection and level detection both act on the inverted value.

Each pin can raise an interrupt on an edge or on a level, and each of the two kinds has its own enable mask. Edge events are held in a cause register until software acknowledges them. Level requests follow the live pin. One registered request line collects every pin.

Software changes single output or direction bits through set and clear aliases, so it needs no read-modify-write. A blink-enable word is stored and can be read back, but it drives nothing.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every stored word is zero: output latch, direction, blink, polarity, cause, edge mask and level mask. Pins are driven with `pin_out`=0 and `pin_oe`=0, and `irq_out` is 0.
- R2: The output latch (0x00), direction (0x04), blink (0x08), polarity (0x0C), edge mask (0x18) and level mask (0x1C) are each written by a plain write and read back unchanged. Read data appears on `bus_rdata` one cycle after `bus_re` and holds until the next read. A direction bit of 1 makes the pin an output; `pin_oe` equals the direction word and `pin_out` equals the latch.
- R3: A write to 0x28 sets, and a write to 0x2C clears, exactly those direction bits that are 1 in the write data. All other direction bits keep their value.
- R4: A write to 0x30 sets, and a write to 0x34 clears, exactly those output-latch bits that are 1 in the write data. All other latch bits keep their value.
- R5: Reading 0x10 returns each pin after the two-flop synchroniser, XORed with its polarity bit.
- R6: A 0-to-1 change of a pin's post-polarity value between two consecutive cycles sets that pin's bit in the cause register (read at 0x14), whatever the masks hold. With a polarity bit of 1, a falling pin edge is the event.
- R7: Writing 1 to a cause bit at 0x14 clears it, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R8: A level request is the post-polarity pin value ANDed with the level mask. It is not latched, so it disappears once the pin goes inactive. With a polarity bit of 1, it is an active-low request.
- R9: `irq_out` is registered and reflects the OR over all pins of (cause AND edge mask) OR (post-polarity input AND level mask) from the cycle before. With every mask bit zero, `irq_out` stays 0.
- R10: A read of any other address returns zero. This includes the four alias addresses and any address that is not a multiple of 4. A write to any other address, including 0x10, changes nothing.
- R11: The blink word is only stored. Writing it has no effect on `pin_out`, `pin_oe` or `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
Take a pin change driven between clock edges as the reference point:
- The synchronised value, and with it the level request, is present after the second following edge.
- The level interrupt reaches `irq_out` after the third edge.
- A cause bit is set after the third edge.
- An edge interrupt reaches `irq_out` after the fourth edge.
- A register write takes effect at the edge that captures it.
- A read returns its word after that same edge.

The bench drives every stimulus on a falling clock edge. It checks the interrupt line at the falling edge just before and just after the cycle in which the result is due, so a one-cycle shift in either direction fails. The same-cycle clear-versus-edge case is lined up by counting edges from the pin change, so that the clear write is captured in the same edge as the new event.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_DOUT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h04;
    localparam logic [ADDR_W-1:0] A_BLINK = 6'h08;
    localparam logic [ADDR_W-1:0] A_POL   = 6'h0C;
    localparam logic [ADDR_W-1:0] A_DIN   = 6'h10;
    localparam logic [ADDR_W-1:0] A_CAUSE = 6'h14;
    localparam logic [ADDR_W-1:0] A_EMASK = 6'h18;
    localparam logic [ADDR_W-1:0] A_LMASK = 6'h1C;
    localparam logic [ADDR_W-1:0] A_CSET  = 6'h28;
    localparam logic [ADDR_W-1:0] A_CCLR  = 6'h2C;
    localparam logic [ADDR_W-1:0] A_DSET  = 6'h30;
    localparam logic [ADDR_W-1:0] A_DCLR  = 6'h34;

    // Addresses that return stored data on a read
    function automatic logic rd_mapped(logic [ADDR_W-1:0] a);
        case (a)
            A_DOUT, A_CTRL, A_BLINK, A_POL,
            A_DIN, A_CAUSE, A_EMASK, A_LMASK: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    // Addresses at which a write has an effect
    function automatic logic wr_mapped(logic [ADDR_W-1:0] a);
        case (a)
            A_DOUT, A_CTRL, A_BLINK, A_POL, A_CAUSE,
            A_EMASK, A_LMASK, A_CSET, A_CCLR, A_DSET, A_DCLR: return 1'b1;
            default:                                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    input  logic              re,
    output logic [W-1:0]      rdata,
    input  logic [W-1:0]      din_view,
    input  logic [W-1:0]      cause_view,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      ctrl,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      emask,
    output logic [W-1:0]      lmask,
    output logic [W-1:0]      cause_clr
);

    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] ctrl;
        logic [W-1:0] blink;
        logic [W-1:0] pol;
        logic [W-1:0] emask;
        logic [W-1:0] lmask;
        logic [W-1:0] rdata;
    } regs_t;

    regs_t        r_d, r_q;
    logic [W-1:0] rd_mux;

    always_comb begin
        case (addr)
            A_DOUT:  rd_mux = r_q.dout;
            A_CTRL:  rd_mux = r_q.ctrl;
            A_BLINK: rd_mux = r_q.blink;
            A_POL:   rd_mux = r_q.pol;
            A_DIN:   rd_mux = din_view;
            A_CAUSE: rd_mux = cause_view;
            A_EMASK: rd_mux = r_q.emask;
            A_LMASK: rd_mux = r_q.lmask;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        cause_clr = '0;
        if (we) begin
            case (addr)
                A_DOUT:  r_d.dout  = wdata;
                A_CTRL:  r_d.ctrl  = wdata;
                A_BLINK: r_d.blink = wdata;
                A_POL:   r_d.pol   = wdata;
                A_EMASK: r_d.emask = wdata;
                A_LMASK: r_d.lmask = wdata;
                A_CSET:  r_d.ctrl  = r_q.ctrl | wdata;
                A_CCLR:  r_d.ctrl  = r_q.ctrl & ~wdata;
                A_DSET:  r_d.dout  = r_q.dout | wdata;
                A_DCLR:  r_d.dout  = r_q.dout & ~wdata;
                A_CAUSE: cause_clr = wdata;
                default: ;
            endcase
        end
        if (re) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign dout  = r_q.dout;
    assign ctrl  = r_q.ctrl;
    assign pol   = r_q.pol;
    assign emask = r_q.emask;
    assign lmask = r_q.lmask;

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] emask,
    input  logic [W-1:0] lmask,
    input  logic [W-1:0] cause_clr,
    output logic [W-1:0] inv_view,
    output logic [W-1:0] cause,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] cause;
        logic         irq;
    } irq_st_t;

    irq_st_t      s_d, s_q;
    logic [W-1:0] inv;
    logic [W-1:0] rise;
    logic [W-1:0] req;

    // per-pin detection: polarity first, then edge and level terms
    for (genvar p = 0; p < W; p++) begin : g_pin
        assign inv[p]  = sync_in[p] ^ pol[p];
        assign rise[p] = inv[p] & ~s_q.prev[p];
        assign req[p]  = (s_q.cause[p] & emask[p]) | (inv[p] & lmask[p]);
    end

    always_comb begin
        s_d       = s_q;
        s_d.prev  = inv;
        s_d.cause = (s_q.cause & ~cause_clr) | rise;
        s_d.irq   = |req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign inv_view = inv;
    assign cause    = s_q.cause;
    assign irq      = s_q.irq;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_re,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq_out
);

    logic [W-1:0] sync_w, inv_w, cause_w, clr_w;
    logic [W-1:0] pol_w, emask_w, lmask_w;

    gpio_bank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_w)
    );

    gpio_bank_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .re         (bus_re),
        .rdata      (bus_rdata),
        .din_view   (inv_w),
        .cause_view (cause_w),
        .dout       (pin_out),
        .ctrl       (pin_oe),
        .pol        (pol_w),
        .emask      (emask_w),
        .lmask      (lmask_w),
        .cause_clr  (clr_w)
    );

    gpio_bank_irq #(.W(W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_w),
        .pol       (pol_w),
        .emask     (emask_w),
        .lmask     (lmask_w),
        .cause_clr (clr_w),
        .inv_view  (inv_w),
        .cause     (cause_w),
        .irq       (irq_out)
    );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic              bus_re,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      cause
);

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !rd_mapped(bus_addr)) |=> (bus_rdata == '0));

    // R10
    unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !wr_mapped(bus_addr)) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R4
    data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DSET) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

    // R4
    data_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DCLR) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

    // R3
    ctrl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CSET) |=> (pin_oe == ($past(pin_oe) | $past(bus_wdata))));

    // R3
    ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CCLR) |=> (pin_oe == ($past(pin_oe) & ~$past(bus_wdata))));

    // R7
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_CAUSE) |=> (($past(cause) & ~cause) == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .cause     (cause_w)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    import gpio_bank_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out;
    logic [31:0]       pin_oe;
    logic              irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        rd(A_POL, v);   check("R1 polarity", v, 32'h0);
        rd(A_EMASK, v); check("R1 edge mask", v, 32'h0);
        rd(A_LMASK, v); check("R1 level mask", v, 32'h0);
        rd(A_BLINK, v); check("R1 blink", v, 32'h0);
        rd(A_CAUSE, v); check("R1 cause", v, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_DOUT, 32'hDEAD_BEEF); rd(A_DOUT, v);
        check("R2 dout readback", v, 32'hDEAD_BEEF);
        check("R2 pin_out", pin_out, 32'hDEAD_BEEF);
        wr(A_CTRL, 32'h1234_5678); rd(A_CTRL, v);
        check("R2 ctrl readback", v, 32'h1234_5678);
        check("R2 pin_oe", pin_oe, 32'h1234_5678);
        wr(A_EMASK, 32'h00FF_0000); rd(A_EMASK, v);
        check("R2 edge mask", v, 32'h00FF_0000);
        wr(A_LMASK, 32'h0000_FF00); rd(A_LMASK, v);
        check("R2 level mask", v, 32'h0000_FF00);
        wr(A_EMASK, 32'h0); wr(A_LMASK, 32'h0);
        wr(A_POL, 32'h5555_AAAA); rd(A_POL, v);
        check("R2 polarity", v, 32'h5555_AAAA);
        wr(A_POL, 32'h0); idle(3);
        wr(A_BLINK, 32'hFFFF_FFFF); rd(A_BLINK, v);
        check("R11 blink readback", v, 32'hFFFF_FFFF);
        check("R11 blink leaves pin_out", pin_out, 32'hDEAD_BEEF);
        check("R11 blink leaves pin_oe", pin_oe, 32'h1234_5678);
        check("R11 blink leaves irq", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_00F0);
        wr(A_CSET, 32'h0000_0003);
        check("R3 ctrl set", pin_oe, 32'h0000_00F3);
        wr(A_CCLR, 32'h0000_0010);
        check("R3 ctrl clear", pin_oe, 32'h0000_00E3);
        rd(A_CTRL, v); check("R3 ctrl readback", v, 32'h0000_00E3);
        wr(A_DOUT, 32'h0F00_0000);
        wr(A_DSET, 32'h8000_0001);
        check("R4 data set", pin_out, 32'h8F00_0001);
        wr(A_DCLR, 32'h0100_0001);
        check("R4 data clear", pin_out, 32'h8E00_0000);
        wr(A_DSET, 32'h0);
        check("R4 zero set word", pin_out, 32'h8E00_0000);
        rd(A_DSET, v); check("R10 alias reads zero", v, 32'h0);
    endtask

    task automatic t_datain();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'hA5A5_0F0F;
        idle(3);
        rd(A_DIN, v); check("R5 data in", v, 32'hA5A5_0F0F);
        wr(A_POL, 32'hFFFF_0000);
        rd(A_DIN, v); check("R5 data in inverted", v, 32'h5A5A_0F0F);
        @(negedge clk); pin_in = 32'h0;
        wr(A_POL, 32'h0); idle(3);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); check("R7 cause cleared", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        @(negedge clk); pin_in[3] = 1'b1; idle(4);
        rd(A_CAUSE, v); check("R6 rising edge latched", v, 32'h0000_0008);
        wr(A_CAUSE, 32'h8);
        @(negedge clk); pin_in[3] = 1'b0; idle(4);
        rd(A_CAUSE, v); check("R6 falling edge ignored", v, 32'h0);
        wr(A_POL, 32'h20); idle(3);
        wr(A_CAUSE, 32'h20);
        @(negedge clk); pin_in[5] = 1'b1; idle(4);
        rd(A_CAUSE, v); check("R6 inverted rise ignored", v, 32'h0);
        @(negedge clk); pin_in[5] = 1'b0; idle(4);
        rd(A_CAUSE, v); check("R6 inverted falling edge", v, 32'h0000_0020);
        @(negedge clk); pin_in[3] = 1'b1; idle(4);
        rd(A_CAUSE, v); check("R6 two causes", v, 32'h0000_0028);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, v); check("R7 write zero keeps", v, 32'h0000_0028);
        wr(A_CAUSE, 32'h8);
        rd(A_CAUSE, v); check("R7 write one clears", v, 32'h0000_0020);
        @(negedge clk); pin_in[3] = 1'b0; idle(4);
        // new edge and clear captured at the same clock edge
        @(negedge clk); pin_in[3] = 1'b1;
        @(negedge clk);
        wr(A_CAUSE, 32'h8);
        rd(A_CAUSE, v); check("R7 edge wins over clear", v, 32'h0000_0028);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); check("R7 final clear", v, 32'h0);
    endtask

    task automatic t_irq_edge();
        logic [31:0] v;
        wr(A_EMASK, 32'h80);
        check("R9 idle irq", {31'h0, irq_out}, 32'h0);
        @(negedge clk); pin_in[7] = 1'b1;
        idle(3); check("R9 edge irq not early", {31'h0, irq_out}, 32'h0);
        idle(1); check("R9 edge irq on time", {31'h0, irq_out}, 32'h1);
        @(negedge clk); pin_in[7] = 1'b0; idle(4);
        check("R6 edge irq stays latched", {31'h0, irq_out}, 32'h1);
        wr(A_CAUSE, 32'h80);
        idle(1); check("R7 irq drops after ack", {31'h0, irq_out}, 32'h0);
        wr(A_EMASK, 32'h0);
        @(negedge clk); pin_in[7] = 1'b1; idle(5);
        check("R9 masked edge no irq", {31'h0, irq_out}, 32'h0);
        rd(A_CAUSE, v); check("R6 cause set while masked", v, 32'h80);
        wr(A_CAUSE, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq_level();
        logic [31:0] v;
        wr(A_LMASK, 32'h200);
        @(negedge clk); pin_in[9] = 1'b1;
        idle(2); check("R8 level irq not early", {31'h0, irq_out}, 32'h0);
        idle(1); check("R8 level irq on time", {31'h0, irq_out}, 32'h1);
        @(negedge clk); pin_in[9] = 1'b0; idle(4);
        check("R8 level irq follows pin", {31'h0, irq_out}, 32'h0);
        rd(A_CAUSE, v); check("R8 edge cause separate", v, 32'h200);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        wr(A_POL, 32'h220); idle(3);
        check("R8 active-low level", {31'h0, irq_out}, 32'h1);
        wr(A_LMASK, 32'h0); idle(2);
        check("R9 masked level no irq", {31'h0, irq_out}, 32'h0);
        wr(A_POL, 32'h0); idle(3);
        wr(A_CAUSE, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [31:0] po, oe;
        po = pin_out; oe = pin_oe;
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h01, 32'hFFFF_FFFF);
        wr(A_DIN, 32'hFFFF_FFFF);
        check("R10 pin_out untouched", pin_out, po);
        check("R10 pin_oe untouched", pin_oe, oe);
        rd(A_POL, v);   check("R10 polarity untouched", v, 32'h0);
        rd(A_EMASK, v); check("R10 edge mask untouched", v, 32'h0);
        rd(6'h20, v);   check("R10 unmapped read", v, 32'h0);
        rd(6'h05, v);   check("R10 misaligned read", v, 32'h0);
        rd(A_DIN, v);   check("R10 data in not written", v, pin_in);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_alias();
        t_datain();
        t_edge();
        t_w1c();
        t_irq_edge();
        t_irq_level();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule